// File: doc/BRIEF.md
# Dual-Channel Phase-Correct PWM Generator

This block produces two pulse-width-modulated outputs from a single shared up/down counter. The counter climbs from zero to a selectable TOP value, turns around, and descends back to zero, forever. It moves only on cycles where the count-enable input is high, so a prescaler outside the block sets the rate. Because the ramp is symmetric, each output pulse is centred on the counter's zero point. The result is phase-correct PWM with a period of twice TOP enabled cycles.

Each channel compares the counter with its own compare value and has its own 2-bit mode. In the normal mode the output drops when the counter matches on the way up and rises when it matches on the way down. In the inverted mode the two actions swap. Compare values pass through a shadow stage and take effect only as the counter turns around at TOP, so a new duty cycle never splits a pulse. The resolution select picks an 8-, 9- or 10-bit counter range.

Top module: `dual_slope_pwm`

## Requirements
- R1: While reset is high and on the first cycle after it, the counter is zero and its direction is up, and both PWM outputs are low.
- R2: Each enabled cycle moves the counter one step toward TOP while rising and toward zero while falling. Direction reverses at TOP and at zero, so an output repeats every 2*TOP enabled cycles.
- R3: The resolution select gives TOP = 255 for code 0, 511 for code 1 and 1023 for codes 2 and 3.
- R4: Mode code 2'b10 (normal) drives the output low on a match while rising and high on a match while falling, so the high time per period is 2*compare cycles.
- R5: Mode code 2'b11 (inverted) drives the output high on a match while rising and low on a match while falling, so the high time per period is 2*(TOP-compare) cycles.
- R6: With mode bit 1 clear (codes 2'b00, 2'b01), the channel's output is low from the cycle after the mode is applied. Its internal level is held and is driven again when the channel is reconnected.
- R7: Only bits [9:0] of each 16-bit compare input take part in matching; bits [15:10] have no effect.
- R8: A compare input is captured into a shadow stage every cycle. It becomes the active compare value only on the enabled step that leaves TOP, so a change made mid-period has no effect until the next turnaround.
- R9: While the count enable is low, the counter, its direction and both outputs hold their values. Enabling on every second cycle doubles the output period.
- R10: The two channels share the counter but use independent compare values and modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable (prescaled tick) |
| res_sel | input | 2 | Resolution select: 0 = 8-bit, 1 = 9-bit, 2/3 = 10-bit |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| mode_a | input | 2 | Output mode, channel A |
| mode_b | input | 2 | Output mode, channel B |
| pwm_a | output | 1 | PWM output, channel A (registered) |
| pwm_b | output | 1 | PWM output, channel B (registered) |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, an 8-bit base resolution and 16-bit compare inputs. At those values the whole range of the resolution select can be reached, including the code that clamps to 10 bits. The upper compare bits above the counter width can also be driven to non-zero values to show that they are masked. A full 8-bit period is only 510 cycles, so many turnarounds occur within the run. This exercises shadow loading, the alternating enable and the disconnect-and-reconnect case. The 10-bit period of 2046 cycles stays cheap enough to measure directly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    RES_8   = 2'd0,
    RES_9   = 2'd1,
    RES_10  = 2'd2,
    RES_10X = 2'd3
  } res_e;

  // Output level written on a compare match.
  // dir_up: counter is rising; inv: mode bit 0 (inverted polarity).
  function automatic logic match_level(input logic dir_up, input logic inv);
    return ~(dir_up ^ inv);
  endfunction

endpackage

// File: rtl/pwm_slope_counter.sv
module pwm_slope_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt_q,
  output logic             up_q,
  output logic             turn
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Step that leaves TOP (also used when TOP shrank below the count).
  always_comb turn = en && up_q && (cnt_q >= top);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en) begin
      if (up_q) begin
        if (cnt_q >= top) begin
          cnt_q <= cnt_q - ONE;
          up_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_q <= ONE;
          up_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_cmp_buffer.sv
module pwm_cmp_buffer #(
  parameter int CMP_W = 16,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMP_W-1:0] cmp_in,
  input  logic             load,
  output logic [CNT_W-1:0] act_q
);

  logic [CNT_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= cmp_in[CNT_W-1:0];
      if (load) act_q <= shadow_q;
    end
  end

endmodule

// File: rtl/pwm_out_channel.sv
module pwm_out_channel #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       mode,
  output logic             pin_q
);

  import pwm_pkg::*;

  logic lvl_q;
  logic lvl_next;
  logic connected;
  logic hit;

  always_comb begin
    connected = mode[1];
    hit       = (cnt == cmp);
    lvl_next  = lvl_q;
    if (connected && hit) lvl_next = match_level(dir_up, mode[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      lvl_q <= lvl_next;
      pin_q <= connected & lvl_next;
    end
  end

endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm #(
  parameter int CNT_W  = 10,
  parameter int BASE_W = 8,
  parameter int CMP_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [1:0]       res_sel,
  input  logic [CMP_W-1:0] cmp_a,
  input  logic [CMP_W-1:0] cmp_b,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  output logic             pwm_a,
  output logic             pwm_b
);

  localparam int NCH = 2;

  logic [CNT_W-1:0]            top_val;
  logic [CNT_W-1:0]            cnt_q;
  logic                        up_q;
  logic                        turn;
  logic [NCH-1:0][CMP_W-1:0]   cmp_in;
  logic [NCH-1:0][1:0]         mode_in;
  logic [NCH-1:0][CNT_W-1:0]   act_q;
  logic [NCH-1:0]              pin_q;

  always_comb begin
    int w;
    w = BASE_W + int'(res_sel);
    if (w > CNT_W) w = CNT_W;
    top_val = CNT_W'((1 << w) - 1);
  end

  assign cmp_in[0]  = cmp_a;
  assign cmp_in[1]  = cmp_b;
  assign mode_in[0] = mode_a;
  assign mode_in[1] = mode_b;
  assign pwm_a      = pin_q[0];
  assign pwm_b      = pin_q[1];

  pwm_slope_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (cnt_en),
    .top   (top_val),
    .cnt_q (cnt_q),
    .up_q  (up_q),
    .turn  (turn)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_cmp_buffer #(.CMP_W(CMP_W), .CNT_W(CNT_W)) u_buf (
      .clk    (clk),
      .rst    (rst),
      .cmp_in (cmp_in[ch]),
      .load   (turn),
      .act_q  (act_q[ch])
    );

    pwm_out_channel #(.CNT_W(CNT_W)) u_out (
      .clk    (clk),
      .rst    (rst),
      .cnt    (cnt_q),
      .dir_up (up_q),
      .cmp    (act_q[ch]),
      .mode   (mode_in[ch]),
      .pin_q  (pin_q[ch])
    );
  end

endmodule

// File: rtl/dual_slope_pwm_checker.sv
module dual_slope_pwm_checker #(
  parameter int CNT_W = 10,
  parameter int NCH   = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cnt_en,
  input logic [1:0]                mode_a,
  input logic [1:0]                mode_b,
  input logic                      pwm_a,
  input logic                      pwm_b,
  input logic [CNT_W-1:0]          cnt_q,
  input logic                      up_q,
  input logic [CNT_W-1:0]          top_val,
  input logic [NCH-1:0][CNT_W-1:0] act_q
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && up_q && !pwm_a && !pwm_b));

  assert_rise_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && up_q && cnt_q < top_val) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

  assert_fall_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !up_q && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1)));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(cnt_q) && $stable(up_q)));

  assert_disc_a_low_R6: assert property (@(posedge clk) disable iff (rst)
    !mode_a[1] |=> !pwm_a);

  assert_disc_b_low_R6: assert property (@(posedge clk) disable iff (rst)
    !mode_b[1] |=> !pwm_b);

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(cnt_en && up_q && cnt_q >= top_val) |=> $stable(act_q));

endmodule

bind dual_slope_pwm dual_slope_pwm_checker #(.CNT_W(CNT_W), .NCH(2)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt_en  (cnt_en),
  .mode_a  (mode_a),
  .mode_b  (mode_b),
  .pwm_a   (pwm_a),
  .pwm_b   (pwm_b),
  .cnt_q   (cnt_q),
  .up_q    (up_q),
  .top_val (top_val),
  .act_q   (act_q)
);

// File: tb/test_dual_slope_pwm.sv
module test_dual_slope_pwm;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic [15:0] cmp_a = 16'd0;
  logic [15:0] cmp_b = 16'd0;
  logic [1:0]  mode_a = 2'b00;
  logic [1:0]  mode_b = 2'b00;
  logic        pwm_a;
  logic        pwm_b;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int en_pat = 0;  // 0: always on, 1: alternate, 2: off

  always #10 clk = ~clk;  // 50 MHz

  dual_slope_pwm i_dual_slope_pwm (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .res_sel(res_sel),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_a(mode_a), .mode_b(mode_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // ---------------- reference model ----------------
  int m_cnt = 0;
  int m_up = 1;
  int m_sh[2] = '{0, 0};
  int m_act[2] = '{0, 0};
  int m_lvl[2] = '{0, 0};
  int m_pin[2] = '{0, 0};

  function automatic int top_of(input int r);
    if (r == 0) return 255;
    if (r == 1) return 511;
    return 1023;
  endfunction

  always @(posedge clk) begin
    int tp, trn, md, cin;
    if (rst) begin
      m_cnt = 0; m_up = 1;
      for (int c = 0; c < 2; c++) begin
        m_sh[c] = 0; m_act[c] = 0; m_lvl[c] = 0; m_pin[c] = 0;
      end
    end else begin
      tp  = top_of(int'(res_sel));
      trn = (cnt_en && m_up == 1 && m_cnt >= tp) ? 1 : 0;
      for (int c = 0; c < 2; c++) begin
        md  = (c == 0) ? int'(mode_a) : int'(mode_b);
        cin = (c == 0) ? int'(cmp_a) : int'(cmp_b);
        if (md >= 2 && m_cnt == m_act[c]) begin
          if (md == 2) m_lvl[c] = (m_up == 1) ? 0 : 1;
          else         m_lvl[c] = (m_up == 1) ? 1 : 0;
        end
        m_pin[c] = (md >= 2) ? m_lvl[c] : 0;
        if (trn == 1) m_act[c] = m_sh[c];
        m_sh[c] = cin % 1024;
      end
      if (cnt_en) begin
        if (m_up == 1) begin
          if (m_cnt >= tp) begin m_cnt = m_cnt - 1; m_up = 0; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  function automatic string tag_of(input logic [1:0] md);
    if (md == 2'b10) return "R4";
    if (md == 2'b11) return "R5";
    return "R6";
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pwm_a !== 1'(m_pin[0])) begin
        failures++;
        $display("FAIL %s ch A model: actual=%0b expected=%0d", tag_of(mode_a), pwm_a, m_pin[0]);
      end
      checks++;
      if (pwm_b !== 1'(m_pin[1])) begin
        failures++;
        $display("FAIL %s/R10 ch B model: actual=%0b expected=%0d", tag_of(mode_b), pwm_b, m_pin[1]);
      end
    end
  end

  // enable pattern driver
  always @(negedge clk) begin
    case (en_pat)
      0: cnt_en <= 1'b1;
      1: cnt_en <= ~cnt_en;
      default: cnt_en <= 1'b0;
    endcase
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pin_of(input int ch);
    return (ch == 0) ? pwm_a : pwm_b;
  endfunction

  task automatic until_lvl(input int ch, input logic lvl, output int n);
    n = 0;
    while (pin_of(ch) !== lvl) begin
      @(negedge clk);
      n++;
    end
  endtask

  // returns high width and period measured rise-to-rise
  task automatic measure(input int ch, output int hi, output int per);
    int d, lo;
    until_lvl(ch, 1'b0, d);
    until_lvl(ch, 1'b1, d);
    until_lvl(ch, 1'b0, hi);
    until_lvl(ch, 1'b1, lo);
    per = hi + lo;
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    int hi, per, n;
    logic sa, sb;
    bit stable;

    repeat (4) @(negedge clk);
    check(pwm_a == 1'b0 && pwm_b == 1'b0, "R1 outputs in reset", {pwm_a, pwm_b}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_a == 1'b0 && pwm_b == 1'b0, "R1 outputs after reset", {pwm_a, pwm_b}, 0);

    // 8-bit, A normal @100, B inverted @200
    res_sel = 2'd0; cmp_a = 16'd100; cmp_b = 16'd200;
    mode_a = 2'b10; mode_b = 2'b11;
    repeat (600) @(negedge clk);
    measure(0, hi, per);
    check(per == 510, "R2 R3 8-bit period A", per, 510);
    check(hi == 200, "R4 normal high width", hi, 200);
    measure(1, hi, per);
    check(hi == 110, "R5 inverted high width", hi, 110);
    check(per == 510, "R10 8-bit period B", per, 510);

    // R8: change compare right after a rise of A
    until_lvl(0, 1'b0, n);
    until_lvl(0, 1'b1, n);
    cmp_a = 16'd50;
    until_lvl(0, 1'b0, hi);
    check(hi == 200, "R8 old compare holds until TOP", hi, 200);
    until_lvl(0, 1'b1, n);
    until_lvl(0, 1'b0, hi);
    check(hi == 100, "R8 new compare after TOP", hi, 100);

    // R9: alternate enable doubles the period
    en_pat = 1;
    repeat (1200) @(negedge clk);
    measure(0, hi, per);
    check(per == 1020, "R9 half-rate period", per, 1020);

    // R9: enable off holds everything
    en_pat = 2;
    repeat (3) @(negedge clk);
    sa = pwm_a; sb = pwm_b; stable = 1;
    repeat (300) begin
      @(negedge clk);
      if (pwm_a !== sa || pwm_b !== sb) stable = 0;
    end
    check(stable, "R9 outputs frozen while disabled", int'(stable), 1);
    en_pat = 0;

    // R6: disconnect A, pin low; reconnect later
    repeat (137) @(negedge clk);
    mode_a = 2'b01;
    repeat (2) @(negedge clk);
    check(pwm_a == 1'b0, "R6 disconnected pin low", pwm_a, 0);
    repeat (700) @(negedge clk);
    check(pwm_a == 1'b0, "R6 pin stays low", pwm_a, 0);
    mode_a = 2'b10;
    repeat (600) @(negedge clk);

    // 9-bit
    res_sel = 2'd1; cmp_a = 16'd100;
    repeat (2200) @(negedge clk);
    measure(0, hi, per);
    check(per == 1022, "R3 9-bit period", per, 1022);
    measure(1, hi, per);
    check(hi == 2 * (511 - 200), "R5 inverted 9-bit width", hi, 2 * (511 - 200));

    // 10-bit (code 3) with upper compare bits set
    res_sel = 2'd3; cmp_a = 16'hFC64;
    repeat (4200) @(negedge clk);
    measure(0, hi, per);
    check(per == 2046, "R3 10-bit period", per, 2046);
    check(hi == 200, "R7 upper compare bits ignored", hi, 200);
    res_sel = 2'd2;
    repeat (2100) @(negedge clk);
    measure(1, hi, per);
    check(per == 2046, "R3 code 2 period", per, 2046);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule